// File: doc/BRIEF.md
# Wide Parallel Parity Row Chainer

This block finishes the parity computation of a long-block LDPC encoder whose parity bits sit in a memory of `ROWS` rows, each `LANES` bits wide. Earlier logic performs the scattered parity-address XOR updates. This block then runs one chained pass down the rows. Row 0 stays as it is. Every later row is replaced by the XOR of its own old contents and the row above it, which has already been rewritten. All lanes of a row are handled in the same clock.

The block drives a read port and a separate write port of the parity memory, each with its own row address. Reading row r+1 and writing back row r can therefore happen in the same cycle. The read port has one cycle of latency. The most recent result row is kept in a register, so each row costs one read and one write. After the pipeline fills, the block handles one row per clock. A one-cycle `start_i` pulse begins a pass. `busy_o` stays high while the pass runs, and `done_o` pulses once when it ends.

Top module: `parity_row_chain`

## Requirements
- R1: After reset, and while idle with no start, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are all 0.
- R2: A `start_i` high at a clock edge while idle makes `busy_o` high and issues a read of row 0 (`rd_en_o`=1, `rd_addr_o`=0) in the cycle that follows that edge.
- R3: Reads cover rows 0 to ROWS-1 in increasing order, one row per consecutive cycle, with no gaps.
- R4: Row 0 is never written.
- R5: For each row i from 1 to ROWS-1, the block writes the bitwise XOR of the old row i and the newly computed row i-1. Lane j of the result uses only lane j of the operands. After a pass, row i of memory holds the XOR of old rows 0 through i.
- R6: The write of row i happens in the cycle after the cycle in which row i was read. Consecutive writes fall in consecutive cycles.
- R7: `done_o` is high for exactly one cycle, in the cycle after the write of row ROWS-1. `busy_o` goes low in that same cycle, so a pass lasts ROWS+1 busy cycles.
- R8: A `start_i` pulse while `busy_o` is high has no effect on the addresses, the data, or the timing of the running pass.
- R9: A start in the cycle where `done_o` is high is accepted. The next pass then works on the result of the previous pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a chained pass |
| rd_en_o | output | 1 | Parity memory read request |
| rd_addr_o | output | $clog2(ROWS) | Row to read |
| rd_data_i | input | LANES | Row data, valid one cycle after the request |
| wr_en_o | output | 1 | Parity memory write request |
| wr_addr_o | output | $clog2(ROWS) | Row to write |
| wr_data_o | output | LANES | Updated row |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pass-complete pulse |

## Verification
The bench checks read and write addresses, the write data, `busy_o` and `done_o` in every cycle of each pass. It uses several row patterns, including a walking single bit, all ones and random rows, and compares the final memory with prefix XORs it computes itself. One corner case is row 0: a design that wrote it, or that did not seed the chain from it, would corrupt every row. Another is ordering: a design that took the old row i-1 instead of the new one, or that wrote one cycle early or late, would store pairwise XORs or miss the write slot. A start pulse in the middle of a pass would, in a faulty design, restart the read address. A start in the done cycle would be lost by a design that cleared busy too late.

// File: rtl/rowchain_pkg.sv
package rowchain_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_phase_e;
endpackage

// File: rtl/rowchain_lanes.sv
module rowchain_lanes #(
    parameter int LANES = 360
) (
    input  logic [LANES-1:0] old_row_i,
    input  logic [LANES-1:0] above_row_i,
    output logic [LANES-1:0] new_row_o
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign new_row_o[j] = old_row_i[j] ^ above_row_i[j];
    end
endmodule

// File: rtl/rowchain_seq.sv
module rowchain_seq
    import rowchain_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_addr_o,
    output logic             ret_vld_o,
    output logic [ROW_W-1:0] ret_row_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    typedef struct packed {
        seq_phase_e       phase;
        logic [ROW_W-1:0] ptr;
        logic             ret_vld;
        logic [ROW_W-1:0] ret_row;
        logic             done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.ret_vld = (s_q.phase == SEQ_ISSUE);
        s_d.ret_row = s_q.ptr;
        unique case (s_q.phase)
            SEQ_IDLE: begin
                if (start_i) begin
                    s_d.phase = SEQ_ISSUE;
                    s_d.ptr   = '0;
                end
            end
            SEQ_ISSUE: begin
                if (s_q.ptr == LAST_ROW) s_d.phase = SEQ_DRAIN;
                else                     s_d.ptr   = s_q.ptr + 1'b1;
            end
            SEQ_DRAIN: begin
                s_d.phase = SEQ_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.phase = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: SEQ_IDLE, ptr: '0, ret_vld: 1'b0, ret_row: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en_o   = (s_q.phase == SEQ_ISSUE);
    assign rd_addr_o = s_q.ptr;
    assign ret_vld_o = s_q.ret_vld;
    assign ret_row_o = s_q.ret_row;
    assign busy_o    = (s_q.phase != SEQ_IDLE);
    assign done_o    = s_q.done;

    assert_rd_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o <= LAST_ROW));
    assert_rd_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));
    assert_first_read_row0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (rd_en_o && rd_addr_o == '0));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/parity_row_chain.sv
module parity_row_chain #(
    parameter int LANES = 360,
    parameter int ROWS  = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_addr_o,
    input  logic [LANES-1:0] rd_data_i,
    output logic             wr_en_o,
    output logic [ROW_W-1:0] wr_addr_o,
    output logic [LANES-1:0] wr_data_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             ret_vld;
    logic [ROW_W-1:0] ret_row;
    logic [LANES-1:0] chained;
    logic [LANES-1:0] prev_d, prev_q;

    rowchain_seq #(.ROWS(ROWS), .ROW_W(ROW_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .ret_vld_o (ret_vld),
        .ret_row_o (ret_row),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    rowchain_lanes #(.LANES(LANES)) lanes_i (
        .old_row_i   (rd_data_i),
        .above_row_i (prev_q),
        .new_row_o   (chained)
    );

    always_comb begin
        prev_d = prev_q;
        if (ret_vld) begin
            prev_d = (ret_row == '0) ? rd_data_i : chained;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign wr_en_o   = ret_vld && (ret_row != '0);
    assign wr_addr_o = ret_row;
    assign wr_data_o = chained;

    assert_no_row0_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o != '0));
    assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rd_en_o) && wr_addr_o == $past(rd_addr_o)));
    assert_write_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == ROW_W'(ROWS - 1)));
endmodule

// File: tb/parity_row_chain_tb_top.sv
module parity_row_chain_tb_top;
    localparam int LANES   = 12;
    localparam int ROWS    = 5;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int CLK_PER = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rd_en, wr_en, busy, done;
    logic [ROW_W-1:0] rd_addr, wr_addr;
    logic [LANES-1:0] rd_data, wr_data;

    logic [LANES-1:0] mem [ROWS];
    logic [LANES-1:0] expv [ROWS];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    parity_row_chain #(.LANES(LANES), .ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int r = 0; r < ROWS; r++) begin
            case (mode)
                0: mem[r] = '0;
                1: mem[r] = '1;
                2: mem[r] = LANES'(1) << (r % LANES);
                3: mem[r] = (r % 2 == 0) ? LANES'(12'hA5A) : LANES'(12'h3C3);
                default: mem[r] = LANES'($urandom);
            endcase
        end
    endtask

    // start pulse at current negedge; returns at the negedge of the done cycle
    task automatic run_pass(input bit poke);
        expv[0] = mem[0];
        for (int r = 1; r < ROWS; r++) expv[r] = mem[r] ^ expv[r-1];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= ROWS + 2; c++) begin
            bit exp_rd, exp_wr;
            exp_rd = (c <= ROWS);
            exp_wr = (c >= 3) && (c <= ROWS + 1);
            chk(rd_en == exp_rd, (c == 1) ? "R2" : "R3", "rd_en", 64'(rd_en), 64'(exp_rd));
            if (exp_rd) chk(rd_addr == ROW_W'(c - 1), "R3", "rd_addr", 64'(rd_addr), 64'(c - 1));
            chk(wr_en == exp_wr, (c == 2) ? "R4" : "R6", "wr_en", 64'(wr_en), 64'(exp_wr));
            if (exp_wr) begin
                chk(wr_addr == ROW_W'(c - 2), "R6", "wr_addr", 64'(wr_addr), 64'(c - 2));
                chk(wr_data == expv[c-2], "R5", "wr_data", 64'(wr_data), 64'(expv[c-2]));
            end
            chk(busy == (c <= ROWS + 1), "R7", "busy", 64'(busy), 64'(c <= ROWS + 1));
            chk(done == (c == ROWS + 2), "R7", "done", 64'(done), 64'(c == ROWS + 2));
            if (poke && c == 2) start = 1'b1;   // R8: start while busy
            if (poke && c == 3) start = 1'b0;
            if (c < ROWS + 2) @(negedge clk);
        end
        for (int r = 0; r < ROWS; r++)
            chk(mem[r] == expv[r], (r == 0) ? "R4" : "R5", "final row", 64'(mem[r]), 64'(expv[r]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy && !done && !rd_en && !wr_en, "R1", "idle outputs",
                64'({busy, done, rd_en, wr_en}), 64'(0));
        end
        for (int mode = 0; mode < 5; mode++) begin
            fill(mode);
            run_pass(1'b0);
            @(negedge clk);
            chk(!busy && !done, "R1", "idle after pass", 64'({busy, done}), 64'(0));
        end
        for (int k = 0; k < 6; k++) begin
            fill(4);
            run_pass(1'b1);      // R8
            @(negedge clk);
        end
        fill(2);
        run_pass(1'b0);
        run_pass(1'b0);          // R9: started in the done cycle
        run_pass(1'b1);          // R9 with R8 poke
        @(negedge clk);
        chk(!busy, "R9", "idle after chained passes", 64'(busy), 64'(0));
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule